// File: doc/BRIEF.md
# Dual-Flag Input Capture Timer

This block is a free-running counter with an input-capture latch. While its run bit is set the counter advances by one every clock. A transition on an asynchronous input pin passes through a two-flop synchronizer and an edge detector. When it matches the programmed polarity, the current count is frozen into a capture register.

Two events are recorded in separate pending bits: counter wrap and capture. Both share a single interrupt enable. Software drives the block through one five-bit control word. To prepare a capture, software stops the timer, sets the pin as an input (outside this block), chooses the polarity, clears both pending bits, and only then sets the run bit.

The control word uses these bit positions:

| Bit | Name | Meaning |
|---|---|---|
| 0 | run | Counter runs when 1 |
| 1 | irq enable | Gates the interrupt output |
| 2 | overflow pending | Set by counter wrap |
| 3 | capture pending | Set by a capture |
| 4 | polarity | 1 = rising, 0 = falling |

Top module: `capture_timer`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0, and the count, the capture register and the interrupt output are all 0.
- R2: While the run bit (bit 0) is 1, the count rises by exactly one per clock. While the run bit is 0, the count holds.
- R3: When the count is all ones and the timer is running, the next clock wraps the count to 0 and sets the overflow pending bit (bit 2).
- R4: Bit 4 of the control word selects the capture edge: 1 for rising, 0 for falling. The opposite edge never causes a capture. A pin change sampled at clock edge k is captured at clock edge k+2.
- R5: On a capture, the capture register takes the count held just before that clock edge, and the capture pending bit (bit 3) sets on the same edge. While the run bit is 0, pin edges change neither the capture register nor bit 3.
- R6: When a capture and a counter wrap fall on the same clock edge, both pending bits set, and the capture register holds the pre-wrap value (all ones).
- R7: The interrupt output is 1 exactly when the enable bit (bit 1) is 1 and at least one pending bit is 1.
- R8: A control write with 0 in a pending bit clears that bit only. A write with 1 leaves it unchanged, so software can never set a pending bit.
- R9: A control write always updates the run and enable bits. It updates the polarity bit only if the run bit was 0 before the write.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word write data |
| ctl_rdata | output | 5 | Current control word |
| count_o | output | CNT_W (16) | Running count |
| capture_o | output | CNT_W (16) | Last captured count |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions watch these properties on every cycle:
- the counter steps by one when running and holds when stopped (R2),
- a wrap goes to zero and raises the overflow flag (R3),
- the capture register holds still while stopped (R5),
- the polarity bit holds still while running (R9),
- the interrupt output only appears with the enable set and a flag pending (R7).

Other properties only the bench scenarios can show. These are:
- the two-cycle synchronizer latency and the exact count value captured,
- rejection of the unselected edge,
- coincident capture and wrap yielding the pre-wrap value with both flags,
- per-bit clearing of the pending flags.

// File: rtl/capture_timer_pkg.sv
// Package: shared layout of the capture timer control word.
// Assumes the bit order below is the software-visible contract.
package capture_timer_pkg;

    localparam int CTL_W = 5;

    // Control word, MSB first: polarity, capture flag, overflow flag, enable, run
    typedef struct packed {
        logic rise_sel;   // bit 4: 1 = rising edge captures, 0 = falling
        logic pend_cap;   // bit 3: capture pending
        logic pend_ovf;   // bit 2: overflow pending
        logic irq_en;     // bit 1: interrupt enable
        logic run;        // bit 0: counter runs
    } ctl_t;

endpackage

// File: rtl/capture_sync_edge.sv
// Module: capture_sync_edge
// Brings an asynchronous pin into the clock domain through STAGES flops
// and flags the selected transition for one cycle.
// Assumes STAGES >= 2 and that the pin idles low out of reset.
module capture_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic edge_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              sync_out;

    // Synchronizer shift chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_i};
    end

    // Previous synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_out;
    end

    assign sync_out = sync_q[STAGES-1];

    // Polarity-selected transition detect
    always_comb begin
        if (rise_sel_i) edge_o = sync_out & ~prev_q;
        else            edge_o = ~sync_out & prev_q;
    end

endmodule

// File: rtl/capture_counter.sv
// Module: capture_counter
// Free-running up counter of CNT_W bits, enabled by run_i.
// Reports a wrap for the clock edge on which the count leaves all ones.
module capture_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Count up while running, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (run_i) cnt_q <= cnt_q + CNT_ONE;
    end

    // Wrap happens on the next edge when running at the maximum value
    assign wrap_o  = run_i && (cnt_q == CNT_MAX);
    assign count_o = cnt_q;

endmodule

// File: rtl/capture_ctl_flags.sv
// Module: capture_ctl_flags
// Holds the control word, sets the pending flags from hardware events,
// applies software writes and forms the interrupt.
// Assumes a hardware set wins over a software clear in the same cycle.
module capture_ctl_flags
    import capture_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  ctl_t wdata_i,
    input  logic ovf_set_i,
    input  logic cap_set_i,
    output ctl_t ctl_o,
    output logic irq_o
);

    ctl_t ctl_q;

    // Run and enable bits: plain write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.run    <= 1'b0;
            ctl_q.irq_en <= 1'b0;
        end else if (we_i) begin
            ctl_q.run    <= wdata_i.run;
            ctl_q.irq_en <= wdata_i.irq_en;
        end
    end

    // Polarity bit: writable only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)                   ctl_q.rise_sel <= 1'b0;
        else if (we_i && !ctl_q.run)  ctl_q.rise_sel <= wdata_i.rise_sel;
    end

    // Overflow flag: set by wrap, cleared by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctl_q.pend_ovf <= 1'b0;
        else if (ovf_set_i)                 ctl_q.pend_ovf <= 1'b1;
        else if (we_i && !wdata_i.pend_ovf) ctl_q.pend_ovf <= 1'b0;
    end

    // Capture flag: set by capture, cleared by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctl_q.pend_cap <= 1'b0;
        else if (cap_set_i)                 ctl_q.pend_cap <= 1'b1;
        else if (we_i && !wdata_i.pend_cap) ctl_q.pend_cap <= 1'b0;
    end

    // Interrupt request from the shared enable
    assign irq_o = ctl_q.irq_en & (ctl_q.pend_ovf | ctl_q.pend_cap);
    assign ctl_o = ctl_q;

endmodule

// File: rtl/capture_timer.sv
// Module: capture_timer (top)
// Free-running capture timer: counter, synchronized edge detector,
// capture latch and dual pending flags behind one control word.
// Assumes software stops the timer before changing the polarity.
module capture_timer
    import capture_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] capture_o,
    output logic             irq_o
);

    ctl_t             ctl;
    logic             pin_edge;
    logic             wrap;
    logic             cap_fire;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap_q;

    capture_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (cap_pin),
        .rise_sel_i (ctl.rise_sel),
        .edge_o     (pin_edge)
    );

    capture_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (ctl.run),
        .count_o (cnt),
        .wrap_o  (wrap)
    );

    capture_ctl_flags u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (ctl_we),
        .wdata_i   (ctl_t'(ctl_wdata)),
        .ovf_set_i (wrap),
        .cap_set_i (cap_fire),
        .ctl_o     (ctl),
        .irq_o     (irq_o)
    );

    assign cap_fire = ctl.run & pin_edge;

    // Capture latch: freeze the pre-increment count on a qualified edge
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_q <= '0;
        else if (cap_fire) cap_q <= cnt;
    end

    assign ctl_rdata = ctl;
    assign count_o   = cnt;
    assign capture_o = cap_q;

endmodule

// File: rtl/capture_timer_checker.sv
// Module: capture_timer_checker
// Cycle-by-cycle properties of the capture timer, observed at its ports.
module capture_timer_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       ctl_rdata,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] capture_o,
    input logic             irq_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP = '1;

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[0] && count_o != TOP) |=> count_o == $past(count_o) + ONE);

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[0] |=> $stable(count_o));

    p_wrap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[0] && count_o == TOP) |=> (count_o == '0 && ctl_rdata[2]));

    p_cap_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[0] |=> $stable(capture_o));

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ctl_rdata[1] && (ctl_rdata[2] || ctl_rdata[3])));

    p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[1] && (ctl_rdata[2] || ctl_rdata[3])) |-> irq_o);

    p_pol_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[0] |=> $stable(ctl_rdata[4]));

endmodule

bind capture_timer capture_timer_checker #(.CNT_W(CNT_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_rdata (ctl_rdata),
    .count_o   (count_o),
    .capture_o (capture_o),
    .irq_o     (irq_o)
);

// File: tb/capture_timer_bench.sv
module capture_timer_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_pin = 1'b0;
    logic         ctl_we = 1'b0;
    logic [4:0]   ctl_wdata = '0;
    logic [4:0]   ctl_rdata;
    logic [W-1:0] count_o;
    logic [W-1:0] capture_o;
    logic         irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    capture_timer u_capture_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pin   (cap_pin),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .count_o   (count_o),
        .capture_o (capture_o),
        .irq_o     (irq_o)
    );

    // Control write table: {write data, expected readback}; bits e,pc,po,ie,run
    localparam logic [9:0] VEC [6] = '{
        {5'b10010, 5'b10010},   // R9 polarity accepted while stopped
        {5'b11111, 5'b10011},   // R8 ones in pending bits do not set them
        {5'b00011, 5'b10011},   // R9 polarity locked while running
        {5'b00000, 5'b10000},   // R9 run was 1 before the write: polarity kept
        {5'b00000, 5'b00000},   // R9 stopped: polarity now writable
        {5'b10000, 5'b10000}    // R9 polarity set again
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] d);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cap_pin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Pin changes at a negedge; capture lands on the third posedge after.
    task automatic capture_probe(input logic lvl, input string req);
        logic [W-1:0] seen;
        cap_pin = lvl;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        seen = count_o;
        check({req, " flag not yet set"}, {31'd0, ctl_rdata[3]}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        check({req, " captured value"}, {16'd0, capture_o}, {16'd0, seen});
        check({req, " capture flag"}, {31'd0, ctl_rdata[3]}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual expired expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] ref_v;
        do_reset();
        @(negedge clk);
        check("R1 ctl", {27'd0, ctl_rdata}, 32'd0);
        check("R1 count", {16'd0, count_o}, 32'd0);
        check("R1 capture", {16'd0, capture_o}, 32'd0);
        check("R1 irq", {31'd0, irq_o}, 32'd0);

        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][9:5]);
            check("R8/R9 table", {27'd0, ctl_rdata}, {27'd0, VEC[i][4:0]});
        end

        // R2 hold then count
        ref_v = count_o;
        repeat (5) @(negedge clk);
        check("R2 hold while stopped", {16'd0, count_o}, {16'd0, ref_v});
        wr(5'b10011);
        ref_v = count_o;
        repeat (4) @(negedge clk);
        check("R2 step per clock", {16'd0, count_o}, {16'd0, ref_v + 16'd4});

        // R4/R5 rising capture, R7 irq
        capture_probe(1'b1, "R5 rising");
        check("R7 irq with capture flag", {31'd0, irq_o}, 32'd1);
        wr(5'b10011);
        check("R8 capture flag cleared", {31'd0, ctl_rdata[3]}, 32'd0);
        check("R7 irq drops", {31'd0, irq_o}, 32'd0);

        // R4 falling edge ignored when rising selected
        cap_pin = 1'b0;
        repeat (6) @(negedge clk);
        check("R4 wrong edge ignored", {31'd0, ctl_rdata[3]}, 32'd0);

        // Switch to falling using the stop-then-program order
        wr(5'b10010);
        wr(5'b00010);
        wr(5'b00011);
        check("R9 falling programmed", {27'd0, ctl_rdata}, 32'h03);
        cap_pin = 1'b1;
        repeat (6) @(negedge clk);
        check("R4 rising ignored in falling mode", {31'd0, ctl_rdata[3]}, 32'd0);
        capture_probe(1'b0, "R4 falling");
        wr(5'b00011);

        // R5 no capture while stopped
        wr(5'b00010);
        ref_v = capture_o;
        cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        cap_pin = 1'b0;
        repeat (6) @(negedge clk);
        check("R5 stopped capture value", {16'd0, capture_o}, {16'd0, ref_v});
        check("R5 stopped capture flag", {31'd0, ctl_rdata[3]}, 32'd0);

        // R3/R6 coincident capture and wrap
        do_reset();
        wr(5'b10001);
        while (count_o != 16'hFFFD) @(negedge clk);
        cap_pin = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R3 at top", {16'd0, count_o}, 32'hFFFF);
        check("R3 no early flag", {30'd0, ctl_rdata[3:2]}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        check("R6 pre-wrap capture", {16'd0, capture_o}, 32'hFFFF);
        check("R6 both flags", {30'd0, ctl_rdata[3:2]}, 32'd3);
        check("R3 wrapped to zero", {16'd0, count_o}, 32'd0);
        check("R7 irq off with enable clear", {31'd0, irq_o}, 32'd0);

        wr(5'b00101);
        check("R8 clear capture only", {30'd0, ctl_rdata[3:2]}, 32'd1);
        wr(5'b00111);
        check("R7 irq from overflow flag", {31'd0, irq_o}, 32'd1);
        wr(5'b00011);
        check("R8 clear overflow", {30'd0, ctl_rdata[3:2]}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule